// File: doc/BRIEF.md
# Receive Ring Buffer Writer

This block takes an incoming Ethernet frame as a byte stream, one byte per beat marked with start-of-frame and end-of-frame flags, and stores it as a record in a packet memory organised as a circular ring of 256-byte pages. The ring is bounded by a first page and a limit page (one past the last usable page). A current-page register says where the next record goes, and a boundary page, supplied by the consumer, marks the oldest record still in use. The memory itself is outside the block; the block drives one synchronous byte write port.

A record starts on a page boundary. Its first four bytes hold a header: a status byte, the page number where the following record will start, and the stored length (frame plus header) as low byte then high byte. The payload follows at offset 4 and wraps from the limit page back to the first page. Short frames are padded with zero bytes to a minimum length. The header is written last, once the length is known, after which the current page moves to the following record and a sticky receive flag is raised. A frame is refused whole when the receiver is halted or when free space in the ring is below one maximum-size frame plus four bytes; a `ring_full` output lets the source see that condition in advance.

The controller is a single state machine. States: IDLE (waiting for a start beat), PAYLOAD (storing frame bytes), PAD (appending zero bytes), HEADER (four header writes), COMMIT (current page update and flag set) and DISCARD (skipping the rest of a refused frame). Transitions: IDLE to PAYLOAD on an accepted start beat; IDLE to PAD or HEADER on an accepted single-beat frame; IDLE to DISCARD on a refused start beat without end flag; PAYLOAD to PAD on an end beat below minimum length, PAYLOAD to HEADER on an end beat at or above it; PAD to HEADER when the minimum length is reached; HEADER to COMMIT after the fourth header byte; COMMIT to IDLE; DISCARD to IDLE on an end beat.

Top module: `rx_ring_writer`

## Requirements
- R1: While `halt` is high a start beat is refused: `busy` stays low, no memory write occurs, `cur_pg` and `rx_irq` are unchanged.
- R2: Free bytes are 256 x (bnd_pg - cur_pg) when cur_pg < bnd_pg, else 256 x ((stop_pg - start_pg) - (cur_pg - bnd_pg)); `ring_full` is high exactly when free bytes are below MAX_FRAME + 4, and a start beat is then refused with no write and no state change.
- R3: Frame bytes of an accepted frame are written in arrival order, one per beat, the first at byte address cur_pg x 256 + 4; memory writes occur only while `busy` is high.
- R4: A payload byte address that would reach stop_pg x 256 continues at start_pg x 256; no write falls outside the ring.
- R5: A frame shorter than MIN_FRAME bytes is followed by zero bytes up to MIN_FRAME stored bytes; the padded length L is the stored length.
- R6: The header occupies cur_pg x 256 + 0..3: status byte at offset 0, following-record page at offset 1, (L + 4) bits 7:0 at offset 2, (L + 4) bits 15:8 at offset 3.
- R7: The status byte is 0x01, or 0x21 when bit 0 of the first frame byte is set.
- R8: The following-record page is cur_pg + ceil((L + 8) / 256); if that is at or above stop_pg, (stop_pg - start_pg) is subtracted.
- R9: After the header is written `cur_pg` takes the following-record page and `rx_irq` is set in the same cycle; `rx_irq` stays set until a cycle with `irq_clr` high, in which a new set takes priority.
- R10: `busy` rises in the cycle after an accepted start beat and falls in the cycle `cur_pg` updates; beats and `cur_wr` while busy have no effect; `cur_wr` while not busy loads `cur_wdata`, and a start beat in the same cycle is refused.
- R11: After reset `cur_pg` is 0 and `busy`, `rx_irq` and `mem_we` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| halt | input | 1 | Receiver halted; refuse new frames |
| start_pg | input | ADDR_W-8 | First page of the ring |
| stop_pg | input | ADDR_W-8 | Page one past the last ring page |
| bnd_pg | input | ADDR_W-8 | Boundary page held by the consumer |
| cur_wr | input | 1 | Load current page |
| cur_wdata | input | ADDR_W-8 | Value for current page load |
| in_valid | input | 1 | Stream beat valid |
| in_sof | input | 1 | Beat is the first byte of a frame |
| in_eof | input | 1 | Beat is the last byte of a frame |
| in_data | input | 8 | Frame byte |
| irq_clr | input | 1 | Clear receive flag |
| mem_we | output | 1 | Packet memory write enable |
| mem_addr | output | ADDR_W | Packet memory byte address |
| mem_wdata | output | 8 | Packet memory write byte |
| cur_pg | output | ADDR_W-8 | Current page |
| ring_full | output | 1 | Free space below one maximum frame |
| busy | output | 1 | A frame is being stored |
| rx_irq | output | 1 | Sticky receive-complete flag |

## Verification
Frames are swept over every starting page of a six-page ring and over lengths chosen at the padding edge (1, 59, 60, 61) and at the page-span edge (247, 248, 249, where the record grows from one page to two), up to the maximum length; starting pages near the limit make the payload and the link page wrap, while alternating first-byte parity separates the two status encodings. Free-space cases are driven with the current page both below and above the boundary, one page short and one page over the threshold, telling the two branches of the space formula apart. A poke of a start beat and a current-page load during padding shows that busy-time input leaves the record and the link untouched, and a halted start shows a refusal with the memory left intact.

// File: rtl/rxr_pkg.sv
package rxr_pkg;
    localparam int LEN_W = 16;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PAYLOAD,
        ST_PAD,
        ST_HEADER,
        ST_COMMIT,
        ST_DISCARD
    } rxr_state_e;

    localparam logic [7:0] STAT_GOOD  = 8'h01;
    localparam logic [7:0] STAT_GROUP = 8'h20;
endpackage

// File: rtl/rxr_space.sv
module rxr_space #(
    parameter int PG_W      = 8,
    parameter int MAX_FRAME = 1514
) (
    input  logic [PG_W-1:0] start_pg,
    input  logic [PG_W-1:0] stop_pg,
    input  logic [PG_W-1:0] bnd_pg,
    input  logic [PG_W-1:0] cur_pg,
    output logic            full
);
    localparam logic [31:0] NEED_BYTES = 32'(MAX_FRAME + 4);

    logic [PG_W:0] ring_pg;
    logic [PG_W:0] free_pg;

    always_comb begin
        ring_pg = {1'b0, stop_pg} - {1'b0, start_pg};
        if (cur_pg < bnd_pg)
            free_pg = {1'b0, bnd_pg} - {1'b0, cur_pg};
        else
            free_pg = ring_pg - ({1'b0, cur_pg} - {1'b0, bnd_pg});
        full = 32'({free_pg, 8'h00}) < NEED_BYTES;
    end
endmodule

// File: rtl/rxr_link.sv
module rxr_link #(
    parameter int PG_W = 8
) (
    input  logic [PG_W-1:0] cur_pg,
    input  logic [PG_W-1:0] start_pg,
    input  logic [PG_W-1:0] stop_pg,
    input  logic [15:0]     total_len,
    output logic [PG_W-1:0] next_pg
);
    localparam int RW = PG_W + 10;

    logic [8:0]    span;
    logic [RW-1:0] raw;
    logic [RW-1:0] ring;

    always_comb begin
        span    = 9'(({1'b0, total_len} + 17'd259) >> 8);
        raw     = RW'(cur_pg) + RW'(span);
        ring    = RW'(stop_pg) - RW'(start_pg);
        next_pg = PG_W'((raw >= RW'(stop_pg)) ? (raw - ring) : raw);
    end
endmodule

// File: rtl/rxr_step.sv
module rxr_step #(
    parameter int ADDR_W = 16
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [ADDR_W-9:0] start_pg,
    input  logic [ADDR_W-9:0] stop_pg,
    output logic [ADDR_W-1:0] addr_next
);
    logic [ADDR_W-1:0] inc;

    always_comb begin
        inc = addr + ADDR_W'(1);
        if (inc == {stop_pg, 8'h00})
            addr_next = {start_pg, 8'h00};
        else
            addr_next = inc;
    end
endmodule

// File: rtl/rx_ring_writer.sv
module rx_ring_writer
    import rxr_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int MAX_FRAME = 1514,
    parameter int MIN_FRAME = 60
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              halt,
    input  logic [ADDR_W-9:0] start_pg,
    input  logic [ADDR_W-9:0] stop_pg,
    input  logic [ADDR_W-9:0] bnd_pg,
    input  logic              cur_wr,
    input  logic [ADDR_W-9:0] cur_wdata,
    input  logic              in_valid,
    input  logic              in_sof,
    input  logic              in_eof,
    input  logic [7:0]        in_data,
    input  logic              irq_clr,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_wdata,
    output logic [ADDR_W-9:0] cur_pg,
    output logic              ring_full,
    output logic              busy,
    output logic              rx_irq
);
    localparam int PG_W = ADDR_W - 8;
    localparam logic [LEN_W-1:0] MIN_L = LEN_W'(MIN_FRAME);
    localparam logic [LEN_W-1:0] ONE_L = LEN_W'(1);

    rxr_state_e        state, nxt_state;
    logic [ADDR_W-1:0] wptr_q;
    logic [LEN_W-1:0]  len_q;
    logic [LEN_W-1:0]  len_inc;
    logic [LEN_W-1:0]  total_len;
    logic [1:0]        hdr_idx;
    logic [7:0]        status_q;
    logic [7:0]        hdr_byte;
    logic [PG_W-1:0]   next_pg;
    logic [ADDR_W-1:0] base_addr;
    logic [ADDR_W-1:0] first_addr;
    logic [ADDR_W-1:0] first_next;
    logic [ADDR_W-1:0] run_next;
    logic              start_beat;
    logic              accept;

    assign base_addr  = {cur_pg, 8'h00};
    assign first_addr = base_addr + ADDR_W'(4);
    assign len_inc    = len_q + ONE_L;
    assign total_len  = len_q + LEN_W'(4);
    assign start_beat = in_valid && in_sof;
    assign accept     = start_beat && !halt && !ring_full && !cur_wr;

    rxr_space #(.PG_W(PG_W), .MAX_FRAME(MAX_FRAME)) u_space (
        .start_pg (start_pg),
        .stop_pg  (stop_pg),
        .bnd_pg   (bnd_pg),
        .cur_pg   (cur_pg),
        .full     (ring_full)
    );

    rxr_link #(.PG_W(PG_W)) u_link (
        .cur_pg    (cur_pg),
        .start_pg  (start_pg),
        .stop_pg   (stop_pg),
        .total_len (total_len),
        .next_pg   (next_pg)
    );

    rxr_step #(.ADDR_W(ADDR_W)) u_step_first (
        .addr      (first_addr),
        .start_pg  (start_pg),
        .stop_pg   (stop_pg),
        .addr_next (first_next)
    );

    rxr_step #(.ADDR_W(ADDR_W)) u_step_run (
        .addr      (wptr_q),
        .start_pg  (start_pg),
        .stop_pg   (stop_pg),
        .addr_next (run_next)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt_state;
    end

    // transitions
    always_comb begin
        nxt_state = state;
        unique case (state)
            ST_IDLE: begin
                if (start_beat) begin
                    if (accept) begin
                        if (!in_eof)           nxt_state = ST_PAYLOAD;
                        else if (ONE_L < MIN_L) nxt_state = ST_PAD;
                        else                   nxt_state = ST_HEADER;
                    end else if (!in_eof) begin
                        nxt_state = ST_DISCARD;
                    end
                end
            end
            ST_PAYLOAD: begin
                if (in_valid && in_eof)
                    nxt_state = (len_inc < MIN_L) ? ST_PAD : ST_HEADER;
            end
            ST_PAD: begin
                if (len_inc >= MIN_L) nxt_state = ST_HEADER;
            end
            ST_HEADER: begin
                if (hdr_idx == 2'd3) nxt_state = ST_COMMIT;
            end
            ST_COMMIT:  nxt_state = ST_IDLE;
            ST_DISCARD: begin
                if (in_valid && in_eof) nxt_state = ST_IDLE;
            end
            default: nxt_state = ST_IDLE;
        endcase
    end

    // outputs decoded from state
    always_comb begin
        busy = (state == ST_PAYLOAD) || (state == ST_PAD) ||
               (state == ST_HEADER)  || (state == ST_COMMIT);
        unique case (hdr_idx)
            2'd0: hdr_byte = status_q;
            2'd1: hdr_byte = 8'(next_pg);
            2'd2: hdr_byte = total_len[7:0];
            2'd3: hdr_byte = total_len[15:8];
            default: hdr_byte = 8'h00;
        endcase
    end

    // datapath and registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mem_we    <= 1'b0;
            mem_addr  <= '0;
            mem_wdata <= '0;
            wptr_q    <= '0;
            len_q     <= '0;
            hdr_idx   <= '0;
            status_q  <= '0;
            cur_pg    <= '0;
            rx_irq    <= 1'b0;
        end else begin
            mem_we <= 1'b0;
            if (cur_wr && !busy)
                cur_pg <= cur_wdata;
            if (state == ST_COMMIT)
                rx_irq <= 1'b1;
            else if (irq_clr)
                rx_irq <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (accept) begin
                        mem_we    <= 1'b1;
                        mem_addr  <= first_addr;
                        mem_wdata <= in_data;
                        wptr_q    <= first_next;
                        len_q     <= ONE_L;
                        hdr_idx   <= 2'd0;
                        status_q  <= STAT_GOOD | (in_data[0] ? STAT_GROUP : 8'h00);
                    end
                end
                ST_PAYLOAD: begin
                    if (in_valid) begin
                        mem_we    <= 1'b1;
                        mem_addr  <= wptr_q;
                        mem_wdata <= in_data;
                        wptr_q    <= run_next;
                        len_q     <= len_inc;
                    end
                end
                ST_PAD: begin
                    mem_we    <= 1'b1;
                    mem_addr  <= wptr_q;
                    mem_wdata <= 8'h00;
                    wptr_q    <= run_next;
                    len_q     <= len_inc;
                end
                ST_HEADER: begin
                    mem_we    <= 1'b1;
                    mem_addr  <= base_addr + ADDR_W'(hdr_idx);
                    mem_wdata <= hdr_byte;
                    hdr_idx   <= hdr_idx + 2'd1;
                end
                ST_COMMIT: begin
                    cur_pg <= next_pg;
                end
                ST_DISCARD: begin
                end
                default: begin
                end
            endcase
        end
    end
endmodule

// File: rtl/rx_ring_writer_chk.sv
module rx_ring_writer_chk #(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              halt,
    input logic [ADDR_W-9:0] start_pg,
    input logic [ADDR_W-9:0] stop_pg,
    input logic              in_valid,
    input logic              in_sof,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [ADDR_W-9:0] cur_pg,
    input logic              busy,
    input logic              rx_irq
);
    p_halt_refuse_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && halt && in_valid && in_sof) |=> !busy);

    p_we_only_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> busy);

    p_wr_in_ring_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> ((mem_addr >= {start_pg, 8'h00}) && (mem_addr < {stop_pg, 8'h00})));

    p_flag_on_store_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> rx_irq);

    p_cur_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($stable(cur_pg) || !busy));
endmodule

bind rx_ring_writer rx_ring_writer_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .halt     (halt),
    .start_pg (start_pg),
    .stop_pg  (stop_pg),
    .in_valid (in_valid),
    .in_sof   (in_sof),
    .mem_we   (mem_we),
    .mem_addr (mem_addr),
    .cur_pg   (cur_pg),
    .busy     (busy),
    .rx_irq   (rx_irq)
);

// File: tb/rx_ring_writer_bench.sv
`timescale 1ns/1ps
module rx_ring_writer_bench;
    localparam int AW    = 11;
    localparam int PW    = AW - 8;
    localparam int MAXF  = 300;
    localparam int MINF  = 60;
    localparam int FIRST = 1;
    localparam int LIMIT = 7;
    localparam int RING  = LIMIT - FIRST;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          halt = 1'b0;
    logic [PW-1:0] start_pg = PW'(FIRST);
    logic [PW-1:0] stop_pg = PW'(LIMIT);
    logic [PW-1:0] bnd_pg = '0;
    logic          cur_wr = 1'b0;
    logic [PW-1:0] cur_wdata = '0;
    logic          in_valid = 1'b0;
    logic          in_sof = 1'b0;
    logic          in_eof = 1'b0;
    logic [7:0]    in_data = '0;
    logic          irq_clr = 1'b0;
    logic          mem_we;
    logic [AW-1:0] mem_addr;
    logic [7:0]    mem_wdata;
    logic [PW-1:0] cur_pg;
    logic          ring_full;
    logic          busy;
    logic          rx_irq;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int busy_cycles = 0;
    bit ended = 0;
    logic [7:0] ram [0:(1<<AW)-1];

    always #2.5 clk = ~clk;

    rx_ring_writer #(.ADDR_W(AW), .MAX_FRAME(MAXF), .MIN_FRAME(MINF)) u_rx_ring_writer (
        .clk(clk), .rst_n(rst_n), .halt(halt), .start_pg(start_pg), .stop_pg(stop_pg),
        .bnd_pg(bnd_pg), .cur_wr(cur_wr), .cur_wdata(cur_wdata), .in_valid(in_valid),
        .in_sof(in_sof), .in_eof(in_eof), .in_data(in_data), .irq_clr(irq_clr),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .cur_pg(cur_pg),
        .ring_full(ring_full), .busy(busy), .rx_irq(rx_irq)
    );

    always @(posedge clk) begin
        if (mem_we) ram[mem_addr] <= mem_wdata;
        if (busy) busy_cycles <= busy_cycles + 1;
    end

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            errors = errors + 1;
            $display("FAIL watchdog: actual %0d cycles expected < 150000", cyc);
            finish_run();
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] pat(input int seed, input int i);
        return 8'(seed + i * 7 + (i >> 3));
    endfunction

    task automatic fill_ram();
        @(negedge clk);
        for (int a = 0; a < (1 << AW); a++) ram[a] = 8'hEE;
    endtask

    task automatic set_cur(input int p);
        @(negedge clk); cur_wr = 1'b1; cur_wdata = PW'(p);
        @(negedge clk); cur_wr = 1'b0;
    endtask

    task automatic clr_irq();
        @(negedge clk); irq_clr = 1'b1;
        @(negedge clk); irq_clr = 1'b0;
    endtask

    task automatic send_frame(input int n, input int seed, input bit poke);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b1; in_sof = (i == 0); in_eof = (i == n - 1); in_data = pat(seed, i);
        end
        @(negedge clk);
        in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
        if (poke) begin
            cur_wr = 1'b1; cur_wdata = PW'(5);
            in_valid = 1'b1; in_sof = 1'b1; in_eof = 1'b1; in_data = 8'hAB;
            @(negedge clk);
            cur_wr = 1'b0; in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
        end
        for (int k = 0; k < 4000 && busy; k++) @(negedge clk);
    endtask

    task automatic check_frame(input int c0, input int n, input int seed);
        int L, tot, nxt, base, bad, a, stat;
        logic [7:0] e;
        L = (n < MINF) ? MINF : n;
        tot = L + 4;
        nxt = c0 + (tot + 4 + 255) / 256;
        if (nxt >= LIMIT) nxt = nxt - RING;
        base = c0 * 256;
        stat = (pat(seed, 0) & 8'h01) ? 8'h21 : 8'h01;
        chk(ram[base] == 8'(stat), "R7 status byte", ram[base], stat);
        chk(ram[base+1] == 8'(nxt), "R8 link page", ram[base+1], nxt);
        chk(ram[base+2] == 8'(tot), "R6 length low", ram[base+2], tot & 255);
        chk(ram[base+3] == 8'(tot >> 8), "R6 length high", ram[base+3], tot >> 8);
        bad = 0;
        for (int i = 0; i < L; i++) begin
            a = base + 4 + i;
            if (a >= LIMIT * 256) a = a - RING * 256;
            e = (i < n) ? pat(seed, i) : 8'h00;
            if (ram[a] != e) bad++;
        end
        chk(bad == 0, (n < MINF) ? "R5 R4 R3 padded payload" : "R3 R4 payload", bad, 0);
        chk(cur_pg == PW'(nxt), "R9 current page", cur_pg, nxt);
        chk(rx_irq == 1'b1, "R9 flag set", rx_irq, 1);
    endtask

    initial begin
        int lens [9] = '{1, 59, 60, 61, 200, 247, 248, 249, 300};
        int b0, bbefore;
        repeat (3) @(negedge clk);
        // R11 reset state
        chk(cur_pg == 0 && busy == 0 && rx_irq == 0 && mem_we == 0,
            "R11 reset", {cur_pg, busy, rx_irq, mem_we}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // sweep of starting page and length
        for (int c = FIRST; c < LIMIT; c++) begin
            for (int li = 0; li < 9; li++) begin
                bnd_pg = PW'(c);
                set_cur(c);
                fill_ram();
                send_frame(lens[li], 8'h30 + li * 3 + c, 1'b0);
                check_frame(c, lens[li], 8'h30 + li * 3 + c);
                clr_irq();
                chk(rx_irq == 1'b0, "R9 flag clear", rx_irq, 0);
            end
        end

        // R2 free-space branches
        set_cur(3); bnd_pg = PW'(4); @(negedge clk);
        chk(ring_full == 1'b1, "R2 one page below boundary", ring_full, 1);
        bnd_pg = PW'(5); @(negedge clk);
        chk(ring_full == 1'b0, "R2 two pages below boundary", ring_full, 0);
        set_cur(6); bnd_pg = PW'(1); @(negedge clk);
        chk(ring_full == 1'b1, "R2 wrapped one page", ring_full, 1);
        bnd_pg = PW'(2); @(negedge clk);
        chk(ring_full == 1'b0, "R2 wrapped two pages", ring_full, 0);

        // R2 refusal when full
        bnd_pg = PW'(1);
        fill_ram();
        b0 = busy_cycles;
        send_frame(80, 8'h41, 1'b0);
        repeat (3) @(negedge clk);
        chk(busy_cycles == b0, "R2 refused no busy", busy_cycles - b0, 0);
        chk(cur_pg == PW'(6) && rx_irq == 1'b0, "R2 refused state", {cur_pg, rx_irq}, 12);
        chk(ram[6*256] == 8'hEE && ram[6*256+4] == 8'hEE, "R2 refused memory", ram[6*256+4], 8'hEE);

        // R1 halted receiver
        bnd_pg = PW'(6);
        halt = 1'b1;
        fill_ram();
        bbefore = busy_cycles;
        send_frame(70, 8'h22, 1'b0);
        repeat (3) @(negedge clk);
        chk(busy_cycles == bbefore, "R1 halted no busy", busy_cycles - bbefore, 0);
        chk(cur_pg == PW'(6) && rx_irq == 1'b0, "R1 halted state", {cur_pg, rx_irq}, 12);
        chk(ram[6*256] == 8'hEE && ram[6*256+4] == 8'hEE, "R1 halted memory", ram[6*256+4], 8'hEE);
        halt = 1'b0;

        // R10 input while busy ignored
        set_cur(2); bnd_pg = PW'(2);
        fill_ram();
        send_frame(5, 8'h10, 1'b1);
        check_frame(2, 5, 8'h10);
        chk(cur_pg == PW'(3), "R10 busy poke ignored", cur_pg, 3);
        clr_irq();

        finish_run();
    end
endmodule